// File: doc/BRIEF.md
# TDM B/D Channel Time-Slot Assigner

This block places two byte-wide bearer channels (B1, B2) and one 2-bit signalling channel (D) on a serial TDM bus. The bus frame holds 64 slots of 8 bit clocks each. In the capture direction, the block samples the shared bus during the slots assigned to each channel and presents the collected bits as parallel words. In the drive direction, it shifts parallel channel data onto the bus during the assigned slots. An output enable marks the bit times the block actually drives, and stands for the high-impedance state at every other time.

The D channel takes only two adjacent bit times: a 2-bit sub-slot within a chosen slot. Software writes slot numbers, the D sub-slot and per-channel drive enables into staging registers. These values, together with the parallel drive data, move into the working set only at a frame sync. A change made mid-frame therefore never splits a frame. The whole assignment function is gated by a format-select input.

Top module: `tdm_slot_assigner`

## Requirements
- R1: After reset the capture slots are B1=0, B2=1 and D=slot 2 sub-slot 0. The drive slots are B1=0 and B2=1. Every drive enable is off, every capture output reads 0, and `bus_oe_o` is 0.
- R2: A rising clock edge that samples `fsync_i` high starts a frame, and the bit time after that edge is bit position 1 of slot 0. Each later edge advances one position, with 8 positions per slot and 64 slots per frame, wrapping after slot 63.
- R3: For each B channel, the 8 bus bits of its capture slot are sampled on falling clock edges, first bit as MSB. After the falling edge of the slot's eighth bit, the word appears on `cap_b1_o` or `cap_b2_o` and holds until that slot's next capture.
- R4: Register address 4 holds the D slot in bits 7:2 and the D sub-slot n in bits 1:0. Sub-slot n covers bit positions 2n+1 and 2n+2 of that slot. The first of the two bits lands in `cap_d_o[1]`.
- R5: Register address 2 sets the B1 drive slot in bits 5:0 with its enable in bit 7. Address 3 does the same for B2. An enabled B channel drives its latched byte MSB first during its slot, with `bus_oe_o` high.
- R6: Address 2 bit 6 enables D drive. In the D slot and sub-slot of R4, the latched `drv_d_i[1]` goes out first, then `drv_d_i[0]`.
- R7: A channel whose drive enable is 0 leaves `bus_oe_o` low during its slot. With every enable off, `bus_oe_o` stays low.
- R8: Register writes do not change bus behaviour in the frame in which they occur. They take effect from the next frame start.
- R9: While `fmt_sel_i` is 0, `bus_oe_o` is 0 and the capture outputs keep their values.
- R10: When enabled drive assignments overlap on the same bit time, B1 wins over B2, and B2 wins over D.
- R11: Address 0 sets the B1 capture slot and address 1 the B2 capture slot, each in bits 5:0. Writes to addresses 5 to 7 change nothing.
- R12: The drive data inputs are latched at the frame start. Changing them mid-frame has no effect on the bus until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_sel_i | input | 1 | 1 selects the slot-assigned format |
| fsync_i | input | 1 | Frame sync, sampled on rising edge |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| bus_in_i | input | 1 | Serial bus data sampled by the block |
| bus_out_o | output | 1 | Serial data driven by the block |
| bus_oe_o | output | 1 | 1 when `bus_out_o` is driven, else high impedance |
| drv_b1_i | input | 8 | B1 byte to drive |
| drv_b2_i | input | 8 | B2 byte to drive |
| drv_d_i | input | 2 | D bits to drive |
| cap_b1_o | output | 8 | Last captured B1 byte |
| cap_b2_o | output | 8 | Last captured B2 byte |
| cap_d_o | output | 2 | Last captured D bits |

## Verification
The assertions watch, on every cycle, the properties that do not depend on data. They check that the position counter resets at sync and otherwise steps by one. They check that the working configuration is frozen between syncs. They check that the output enable stays off when the format is deselected or every enable is clear, and that captured words hold while the format is off. The correct bit at each slot and sub-slot, the MSB-first order, the overlap priority and the deferral of mid-frame writes and data changes depend on byte patterns. Only the bench's frame scenarios can show these, by comparing every bus bit time and each captured word against values computed from the register settings.

// File: rtl/tdm_slot_pkg.sv
`timescale 1ns/1ps
package tdm_slot_pkg;
  localparam int SLOT_W = 6;
  localparam int BIT_W  = 3;
  localparam int POS_W  = SLOT_W + BIT_W;
  localparam int B_W    = 1 << BIT_W;
  localparam int D_W    = 2;
  localparam int DSH    = $clog2(D_W);
  localparam int SUB_W  = BIT_W - DSH;
  localparam int N_B    = 2;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;
  localparam int EN_BIT  = REG_W - 1;
  localparam int DEN_BIT = REG_W - 2;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    slot_t [N_B-1:0]  cap_slot;
    slot_t [N_B-1:0]  drv_slot;
    logic  [N_B-1:0]  drv_en;
    slot_t            d_slot;
    logic [SUB_W-1:0] d_sub;
    logic             d_en;
  } cfg_t;

  localparam logic [ADDR_W-1:0] A_CAP_B1 = 3'd0;
  localparam logic [ADDR_W-1:0] A_CAP_B2 = 3'd1;
  localparam logic [ADDR_W-1:0] A_DRV_B1 = 3'd2;
  localparam logic [ADDR_W-1:0] A_DRV_B2 = 3'd3;
  localparam logic [ADDR_W-1:0] A_DSEL   = 3'd4;

  localparam cfg_t CFG_RST = '{
    cap_slot: {slot_t'(1), slot_t'(0)},
    drv_slot: {slot_t'(1), slot_t'(0)},
    drv_en:   '0,
    d_slot:   slot_t'(2),
    d_sub:    '0,
    d_en:     1'b0
  };
endpackage

// File: rtl/tdm_bit_ctr.sv
`timescale 1ns/1ps
module tdm_bit_ctr #(
  parameter int POS_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  output logic [POS_W-1:0] pos_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_o <= '0;
    else if (fsync_i) pos_o <= '0;
    else              pos_o <= pos_o + POS_W'(1);
  end
endmodule

// File: rtl/tdm_slot_cfg.sv
`timescale 1ns/1ps
module tdm_slot_cfg
  import tdm_slot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output cfg_t              act_o
);
  cfg_t stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= CFG_RST;
      act_o   <= CFG_RST;
    end else begin
      if (we_i) begin
        case (addr_i)
          A_CAP_B1: stage_q.cap_slot[0] <= wdata_i[SLOT_W-1:0];
          A_CAP_B2: stage_q.cap_slot[1] <= wdata_i[SLOT_W-1:0];
          A_DRV_B1: begin
            stage_q.drv_slot[0] <= wdata_i[SLOT_W-1:0];
            stage_q.drv_en[0]   <= wdata_i[EN_BIT];
            stage_q.d_en        <= wdata_i[DEN_BIT];
          end
          A_DRV_B2: begin
            stage_q.drv_slot[1] <= wdata_i[SLOT_W-1:0];
            stage_q.drv_en[1]   <= wdata_i[EN_BIT];
          end
          A_DSEL: begin
            stage_q.d_slot <= wdata_i[SUB_W +: SLOT_W];
            stage_q.d_sub  <= wdata_i[SUB_W-1:0];
          end
          default: ;
        endcase
      end
      // a write on the sync edge itself lands one frame later
      if (fsync_i) act_o <= stage_q;
    end
  end
endmodule

// File: rtl/tdm_slot_capture.sv
`timescale 1ns/1ps
module tdm_slot_capture #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         hit_i,
  input  logic         last_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  logic [W-2:0] sh_q;
  logic [W-1:0] sh_nxt;

  assign sh_nxt = {sh_q, bit_i};

  // bus is sampled on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      data_o <= '0;
    end else if (en_i && hit_i) begin
      sh_q <= sh_nxt[W-2:0];
      if (last_i) data_o <= sh_nxt;
    end
  end
endmodule

// File: rtl/tdm_bus_drv.sv
`timescale 1ns/1ps
module tdm_bus_drv
  import tdm_slot_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fsync_i,
  input  logic                      fmt_i,
  input  slot_t                     cur_slot_i,
  input  logic [BIT_W-1:0]          bit_idx_i,
  input  cfg_t                      cfg_i,
  input  logic [N_B-1:0][B_W-1:0]   drv_b_i,
  input  logic [D_W-1:0]            drv_d_i,
  output logic                      out_o,
  output logic                      oe_o
);
  logic [N_B-1:0][B_W-1:0] b_q;
  logic [D_W-1:0]          d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q <= '0;
      d_q <= '0;
    end else if (fsync_i) begin
      b_q <= drv_b_i;
      d_q <= drv_d_i;
    end
  end

  // lowest priority assigned first, B1 last so it wins
  always_comb begin
    oe_o  = 1'b0;
    out_o = 1'b0;
    if (fmt_i) begin
      if (cfg_i.d_en && cur_slot_i == cfg_i.d_slot &&
          bit_idx_i[BIT_W-1:DSH] == cfg_i.d_sub) begin
        oe_o  = 1'b1;
        out_o = d_q[~bit_idx_i[DSH-1:0]];
      end
      for (int i = N_B-1; i >= 0; i--) begin
        if (cfg_i.drv_en[i] && cur_slot_i == cfg_i.drv_slot[i]) begin
          oe_o  = 1'b1;
          out_o = b_q[i][~bit_idx_i];
        end
      end
    end
  end
endmodule

// File: rtl/tdm_slot_assigner.sv
`timescale 1ns/1ps
module tdm_slot_assigner
  import tdm_slot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_sel_i,
  input  logic              fsync_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  input  logic              bus_in_i,
  output logic              bus_out_o,
  output logic              bus_oe_o,
  input  logic [B_W-1:0]    drv_b1_i,
  input  logic [B_W-1:0]    drv_b2_i,
  input  logic [D_W-1:0]    drv_d_i,
  output logic [B_W-1:0]    cap_b1_o,
  output logic [B_W-1:0]    cap_b2_o,
  output logic [D_W-1:0]    cap_d_o
);
  logic [POS_W-1:0]        pos;
  cfg_t                    act_cfg;
  slot_t                   cur_slot;
  logic [BIT_W-1:0]        bit_idx;
  logic [N_B-1:0][B_W-1:0] cap_b;
  logic [N_B-1:0][B_W-1:0] drv_b;

  assign cur_slot = pos[POS_W-1:BIT_W];
  assign bit_idx  = pos[BIT_W-1:0];
  assign drv_b    = {drv_b2_i, drv_b1_i};
  assign cap_b1_o = cap_b[0];
  assign cap_b2_o = cap_b[1];

  tdm_bit_ctr #(.POS_W(POS_W)) i_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fsync_i (fsync_i),
    .pos_o   (pos)
  );

  tdm_slot_cfg i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fsync_i (fsync_i),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .act_o   (act_cfg)
  );

  for (genvar g = 0; g < N_B; g++) begin : g_bcap
    tdm_slot_capture #(.W(B_W)) i_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (fmt_sel_i),
      .hit_i  (cur_slot == act_cfg.cap_slot[g]),
      .last_i (&bit_idx),
      .bit_i  (bus_in_i),
      .data_o (cap_b[g])
    );
  end

  tdm_slot_capture #(.W(D_W)) i_dcap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (fmt_sel_i),
    .hit_i  (cur_slot == act_cfg.d_slot && bit_idx[BIT_W-1:DSH] == act_cfg.d_sub),
    .last_i (&bit_idx[DSH-1:0]),
    .bit_i  (bus_in_i),
    .data_o (cap_d_o)
  );

  tdm_bus_drv i_drv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fsync_i    (fsync_i),
    .fmt_i      (fmt_sel_i),
    .cur_slot_i (cur_slot),
    .bit_idx_i  (bit_idx),
    .cfg_i      (act_cfg),
    .drv_b_i    (drv_b),
    .drv_d_i    (drv_d_i),
    .out_o      (bus_out_o),
    .oe_o       (bus_oe_o)
  );
endmodule

// File: rtl/tdm_slot_assigner_chk.sv
`timescale 1ns/1ps
module tdm_slot_assigner_chk
  import tdm_slot_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fsync_i,
  input logic             fmt_sel_i,
  input logic             bus_oe_o,
  input logic [POS_W-1:0] pos,
  input cfg_t             act_cfg,
  input logic [B_W-1:0]   cap_b1_o,
  input logic [B_W-1:0]   cap_b2_o,
  input logic [D_W-1:0]   cap_d_o
);
  // R2
  pos_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |=> pos == '0);

  // R2
  pos_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsync_i |=> pos == $past(pos) + POS_W'(1));

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsync_i |=> $stable(act_cfg));

  // R9
  oe_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fmt_sel_i |-> !bus_oe_o);

  // R9
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fmt_sel_i |-> ($stable(cap_b1_o) && $stable(cap_b2_o) && $stable(cap_d_o)));

  // R7
  oe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_cfg.drv_en == '0 && !act_cfg.d_en) |-> !bus_oe_o);
endmodule

bind tdm_slot_assigner tdm_slot_assigner_chk i_chk (.*);

// File: tb/test_tdm_slot_assigner.sv
`timescale 1ns/1ps
module test_tdm_slot_assigner;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, fmt, fsync, we, bus_in, bus_out, bus_oe;
  logic [2:0] addr;
  logic [7:0] wdata, b1d, b2d, cb1, cb2;
  logic [1:0] dd, cd;

  int n_chk = 0;
  int n_fail = 0;

  // staged (s_) and active (m_) register model
  int s_cap[2], m_cap[2], s_drv[2], m_drv[2];
  bit s_en[2], m_en[2], s_den, m_den;
  int s_ds, m_ds, s_sub, m_sub;
  logic [7:0] e_cb[2];
  logic [1:0] e_cd;

  tdm_slot_assigner i_tdm_slot_assigner (
    .clk_i(clk), .rst_ni(rst_n), .fmt_sel_i(fmt), .fsync_i(fsync),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .bus_in_i(bus_in), .bus_out_o(bus_out), .bus_oe_o(bus_oe),
    .drv_b1_i(b1d), .drv_b2_i(b2d), .drv_d_i(dd),
    .cap_b1_o(cb1), .cap_b2_o(cb2), .cap_d_o(cd)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int seed);
    return 8'(s * 29 + seed * 71 + 5);
  endfunction

  function automatic void model_wr(input int a, input logic [7:0] d);
    case (a)
      0: s_cap[0] = int'(d[5:0]);
      1: s_cap[1] = int'(d[5:0]);
      2: begin s_drv[0] = int'(d[5:0]); s_en[0] = d[7]; s_den = d[6]; end
      3: begin s_drv[1] = int'(d[5:0]); s_en[1] = d[7]; end
      4: begin s_ds = int'(d[7:2]); s_sub = int'(d[1:0]); end
      default: ;
    endcase
  endfunction

  task automatic cfg_wr(input int a, input logic [7:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = 3'(a); wdata = d;
    model_wr(a, d);
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  // mid: 0 none, 1 register write at position 100, 2 change drv_b1 at position 50
  task automatic run_frame(input string tag, input int seed, input bit f,
                           input int mid, input int ma, input logic [7:0] md);
    int errs;
    logic [7:0] lb[2];
    logic [1:0] ld;
    errs = 0;
    @(posedge clk); #1;
    fsync = 1'b1; fmt = f;
    @(posedge clk); #1;
    fsync = 1'b0;
    m_cap = s_cap; m_drv = s_drv; m_en = s_en; m_den = s_den;
    m_ds = s_ds; m_sub = s_sub;
    lb[0] = b1d; lb[1] = b2d; ld = dd;
    for (int k = 0; k < 512; k++) begin
      int sl, b;
      logic [7:0] pb;
      logic eoe, eout;
      sl = k >> 3; b = k & 7;
      pb = pat(sl, seed);
      bus_in = pb[7-b];
      if (mid == 1 && k == 100) begin we = 1'b1; addr = 3'(ma); wdata = md; model_wr(ma, md); end
      if (mid == 1 && k == 101) we = 1'b0;
      if (mid == 2 && k == 50) b1d = md;
      #1;
      eoe = 1'b0; eout = 1'b0;
      if (f) begin
        if (m_en[0] && sl == m_drv[0]) begin eoe = 1'b1; eout = lb[0][7-b]; end
        else if (m_en[1] && sl == m_drv[1]) begin eoe = 1'b1; eout = lb[1][7-b]; end
        else if (m_den && sl == m_ds && (b >> 1) == m_sub) begin eoe = 1'b1; eout = ld[1-(b&1)]; end
      end
      if (bus_oe !== eoe || (eoe && bus_out !== eout)) begin
        if (errs == 0)
          $display("  %s mismatch at position %0d: oe=%b out=%b expected oe=%b out=%b",
                   tag, k, bus_oe, bus_out, eoe, eout);
        errs++;
      end
      @(posedge clk); #1;
    end
    chk({tag, " bus drive"}, errs, 0);
    if (f) begin
      logic [7:0] pd;
      e_cb[0] = pat(m_cap[0], seed);
      e_cb[1] = pat(m_cap[1], seed);
      pd = pat(m_ds, seed);
      e_cd = pd[7-2*m_sub -: 2];
    end
    chk({tag, " cap B1"}, cb1, e_cb[0]);
    chk({tag, " cap B2"}, cb2, e_cb[1]);
    chk({tag, " cap D"}, cd, e_cd);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset oe", bus_oe, 0);
    chk("R1 reset cap B1", cb1, 0);
    chk("R1 reset cap B2", cb2, 0);
    chk("R1 reset cap D", cd, 0);
  endtask

  task automatic t_default();
    run_frame("R1 R2 R3 R4 R7 default", 1, 1'b1, 0, 0, 8'h00);
  endtask

  task automatic t_drive_b();
    b1d = 8'hA5; b2d = 8'h3C;
    cfg_wr(0, 8'd17); cfg_wr(1, 8'd63);
    cfg_wr(2, 8'h80 | 8'd5); cfg_wr(3, 8'h80 | 8'd9);
    run_frame("R3 R5 R11 drive B", 2, 1'b1, 0, 0, 8'h00);
  endtask

  task automatic t_d_sub();
    cfg_wr(2, 8'hC0 | 8'd5);
    for (int s = 0; s < 4; s++) begin
      dd = 2'(s + 1);
      cfg_wr(4, {6'd12, 2'(s)});
      run_frame($sformatf("R4 R6 D sub-slot %0d", s), 3 + s, 1'b1, 0, 0, 8'h00);
    end
  endtask

  task automatic t_disable();
    cfg_wr(2, 8'h05); cfg_wr(3, 8'h09);
    run_frame("R7 disabled", 8, 1'b1, 0, 0, 8'h00);
  endtask

  task automatic t_shadow();
    run_frame("R8 cap write deferred", 9, 1'b1, 1, 0, 8'd40);
    run_frame("R8 cap write applied", 10, 1'b1, 0, 0, 8'h00);
    run_frame("R8 enable write deferred", 11, 1'b1, 1, 2, 8'h80 | 8'd10);
    run_frame("R8 enable write applied", 12, 1'b1, 0, 0, 8'h00);
  endtask

  task automatic t_fmt_off();
    run_frame("R9 format off", 13, 1'b0, 0, 0, 8'h00);
    run_frame("R9 format back on", 14, 1'b1, 0, 0, 8'h00);
  endtask

  task automatic t_overlap();
    dd = 2'b10;
    cfg_wr(2, 8'hC0 | 8'd20); cfg_wr(3, 8'h80 | 8'd20); cfg_wr(4, {6'd20, 2'd1});
    run_frame("R10 B1 over B2 and D", 15, 1'b1, 0, 0, 8'h00);
    cfg_wr(2, 8'h40 | 8'd20);
    run_frame("R10 B2 over D", 16, 1'b1, 0, 0, 8'h00);
    cfg_wr(3, 8'd20);
    run_frame("R10 D alone", 17, 1'b1, 0, 0, 8'h00);
  endtask

  task automatic t_bad_addr();
    cfg_wr(5, 8'hFF); cfg_wr(6, 8'hFF); cfg_wr(7, 8'hFF);
    run_frame("R11 unused addresses", 18, 1'b1, 0, 0, 8'h00);
  endtask

  task automatic t_data_latch();
    cfg_wr(2, 8'h80 | 8'd30);
    b1d = 8'h11;
    run_frame("R12 data change deferred", 19, 1'b1, 2, 0, 8'hEE);
    run_frame("R12 data change applied", 20, 1'b1, 0, 0, 8'h00);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fmt = 1'b1; fsync = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    bus_in = 1'b0; b1d = '0; b2d = '0; dd = '0;
    s_cap[0] = 0; s_cap[1] = 1; s_drv[0] = 0; s_drv[1] = 1;
    s_en[0] = 0; s_en[1] = 0; s_den = 0; s_ds = 2; s_sub = 0;
    e_cb[0] = '0; e_cb[1] = '0; e_cd = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_default();
    t_drive_b();
    t_d_sub();
    t_disable();
    t_shadow();
    t_fmt_off();
    t_overlap();
    t_bad_addr();
    t_data_latch();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule